// File: doc/BRIEF.md
# Edge-Triggered Interrupt Message Dispatcher

This block turns rising edges on a bank of interrupt input pins into delivery messages for a set of processors. Each pin has a routing entry, supplied as a flat input vector by surrounding logic. The entry gives the vector, delivery mode, destination, destination mode, polarity, trigger mode and a mask bit. When a pin goes from low to high, the block latches a pending edge. It later services that edge by reading the pin's entry and building a message. The destination in the message is resolved into a bitmask of target processors. In physical mode this is a single processor number or an all-processor broadcast. In logical mode each processor's logical-destination byte is matched against the destination.

The message leaves through a valid/ready stream. A message stays on the outputs, unchanged, until `msg_ready` is high at a clock edge. While the output slot is occupied and not being consumed, no pending edge is serviced. Edges keep accumulating in the pending bits and none is lost. An entry that asks for lowest-priority delivery cannot be serviced. It produces a one-cycle `err_pulse` in place of a message, and it waits for the same free slot as a message does.

Top module: `irq_dispatch`

## Requirements
- R1: A pin sampled high at a clock edge after being sampled low at the previous edge gives exactly one message. With `msg_ready` high, that message is valid after the following edge. A pin that stays high gives nothing more. A pin going low gives nothing.
- R2: If bit 22 (mask) of the serviced pin's entry is set, the edge is dropped. No message and no error are produced.
- R3: The entry packs bits [7:0] vector, [15:8] destination, [18:16] delivery mode, [19] destination mode (1 = logical), [20] polarity and [21] trigger. The message carries the destination, delivery mode, destination mode and trigger unchanged, and its level equals the polarity bit.
- R4: When the delivery mode is 3'b111 (external interrupt), the message vector is `legacy_vector` and not the entry's vector.
- R5: In physical mode, destination 8'hFF sets every bit of `msg_targets`.
- R6: In physical mode, any other destination d sets only bit d of `msg_targets`. If d is at or above NCPU, the mask is empty but the message is still valid.
- R7: In logical mode, target bit i is set exactly when byte i of `logical_ids` ANDed with the destination is nonzero.
- R8: Delivery mode 3'b001 (lowest priority), in either destination mode, gives a one-cycle `err_pulse` and no message.
- R9: Pins that rise in the same cycle are all serviced, one per free cycle, in ascending pin order.
- R10: While `msg_valid` is high and `msg_ready` is low, every message output holds its value and nothing new is serviced.
- R11: During and just after reset, `msg_valid` and `err_pulse` are low and every pin is treated as previously low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NPINS | Interrupt input pins |
| route_tbl | input | NPINS*23 | Routing entries, entry p at bits [p*23 +: 23] |
| logical_ids | input | NCPU*8 | Logical-destination byte per processor, byte i for processor i |
| legacy_vector | input | 8 | Vector from the external legacy controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Level, from entry polarity |
| msg_trigger | output | 1 | Trigger mode |
| msg_dest | output | 8 | Destination field |
| msg_targets | output | NCPU | Resolved target processor mask |
| err_pulse | output | 1 | One-cycle pulse for an unsupported delivery mode |

## Verification
Two things can happen in the same cycle: new edges are captured on some pins while another pin's pending edge is being serviced or held back. The bench raises three pins in one cycle and checks that three messages come out on consecutive cycles in ascending pin order. It then holds `msg_ready` low with one message waiting and a second pin pending. The held message must stay stable, and the second pin's message must appear on the edge that consumes the first. A lowest-priority pin raised together with a normal pin must produce the error pulse first and the message one cycle later.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ENTRY_W = 23;
  localparam int DEST_W  = 8;
  localparam int VEC_W   = 8;

  typedef struct packed {
    logic              masked;
    logic              trig;
    logic              pol;
    logic              logical;
    logic [2:0]        dlv;
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vec;
  } route_t;

  localparam logic [2:0]        DLV_LOWPRI = 3'b001;
  localparam logic [2:0]        DLV_EXTINT = 3'b111;
  localparam logic [DEST_W-1:0] DEST_ALL   = 8'hFF;
endpackage

// File: rtl/irqd_edge_capture.sv
module irqd_edge_capture #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] pending
);
  logic [NPINS-1:0] seen;
  logic [NPINS-1:0] rise;

  assign rise = pins & ~seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= '0;
      pending <= '0;
    end else begin
      seen    <= pins;
      // a fresh edge wins over a clear in the same cycle
      pending <= (pending & ~clr) | rise;
    end
  end
endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
  parameter int NPINS = 8,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int p = NPINS - 1; p >= 0; p--) begin
      if (req[p]) idx = IW'(p);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irqd_target_resolve.sv
module irqd_target_resolve #(
  parameter int NCPU = 4
) (
  input  logic            logical,
  input  logic [7:0]      dest,
  input  logic [NCPU*8-1:0] ids,
  output logic [NCPU-1:0] targets
);
  logic bcast;
  assign bcast = (dest == irqd_pkg::DEST_ALL);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit_log;
    logic hit_phys;
    assign hit_log  = |(ids[c*8 +: 8] & dest);
    assign hit_phys = bcast || ({24'd0, dest} == 32'(c));
    assign targets[c] = logical ? hit_log : hit_phys;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NPINS = 8,
  parameter int NCPU  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     irq_pins,
  input  logic [NPINS*23-1:0]  route_tbl,
  input  logic [NCPU*8-1:0]    logical_ids,
  input  logic [7:0]           legacy_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [2:0]           msg_dlv,
  output logic                 msg_logical,
  output logic                 msg_level,
  output logic                 msg_trigger,
  output logic [7:0]           msg_dest,
  output logic [NCPU-1:0]      msg_targets,
  output logic                 err_pulse
);
  import irqd_pkg::*;

  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0] pending;
  logic [NPINS-1:0] clr;
  logic             any;
  logic [IW-1:0]    pick;
  logic             slot_free;
  logic             take;
  route_t           ent;
  logic [NCPU-1:0]  tgt;

  irqd_edge_capture #(.NPINS(NPINS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins    (irq_pins),
    .clr     (clr),
    .pending (pending)
  );

  irqd_prio_pick #(.NPINS(NPINS)) u_pick (
    .req (pending),
    .any (any),
    .idx (pick)
  );

  assign ent       = route_t'(route_tbl[pick*ENTRY_W +: ENTRY_W]);
  assign slot_free = !msg_valid || msg_ready;
  assign take      = any && slot_free;
  assign clr       = take ? (NPINS'(1) << pick) : '0;

  irqd_target_resolve #(.NCPU(NCPU)) u_res (
    .logical (ent.logical),
    .dest    (ent.dest),
    .ids     (logical_ids),
    .targets (tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      err_pulse   <= 1'b0;
      msg_vector  <= '0;
      msg_dlv     <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      msg_dest    <= '0;
      msg_targets <= '0;
    end else begin
      err_pulse <= 1'b0;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (take && !ent.masked) begin
        if (ent.dlv == DLV_LOWPRI) begin
          err_pulse <= 1'b1;
        end else begin
          msg_valid   <= 1'b1;
          msg_vector  <= (ent.dlv == DLV_EXTINT) ? legacy_vector : ent.vec;
          msg_dlv     <= ent.dlv;
          msg_logical <= ent.logical;
          msg_level   <= ent.pol;
          msg_trigger <= ent.trig;
          msg_dest    <= ent.dest;
          msg_targets <= tgt;
        end
      end
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [7:0]      msg_vector,
  input logic [2:0]      msg_dlv,
  input logic            msg_logical,
  input logic [7:0]      msg_dest,
  input logic [NCPU-1:0] msg_targets
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
      $stable(msg_targets) && $stable(msg_dest) && $stable(msg_dlv));

  // R8
  no_lowpri_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_dlv != 3'b001);

  // R5
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical && msg_dest == 8'hFF |-> &msg_targets);

  // R6
  phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical && msg_dest != 8'hFF |-> $onehot0(msg_targets));

  // R6
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical && msg_dest != 8'hFF && {24'd0, msg_dest} >= NCPU
      |-> msg_targets == '0);
endmodule

bind irq_dispatch irqd_chk #(.NCPU(NCPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_vector  (msg_vector),
  .msg_dlv     (msg_dlv),
  .msg_logical (msg_logical),
  .msg_dest    (msg_dest),
  .msg_targets (msg_targets)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int NPINS = 8;
  localparam int NCPU  = 4;
  localparam int EW    = 23;
  localparam int NROWS = 10;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NPINS-1:0]    irq_pins;
  logic [NPINS*EW-1:0] route_tbl;
  logic [NCPU*8-1:0]   logical_ids;
  logic [7:0]          legacy_vector;
  logic                msg_valid, msg_ready;
  logic [7:0]          msg_vector, msg_dest;
  logic [2:0]          msg_dlv;
  logic                msg_logical, msg_level, msg_trigger, err_pulse;
  logic [NCPU-1:0]     msg_targets;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dispatch #(.NPINS(NPINS), .NCPU(NCPU)) dut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .route_tbl(route_tbl),
    .logical_ids(logical_ids), .legacy_vector(legacy_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv(msg_dlv), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_dest(msg_dest), .msg_targets(msg_targets),
    .err_pulse(err_pulse)
  );

  // row: pin[39:37] entry[36:14] kind[13:12] (0 none,1 msg,2 err) vec[11:4] tgt[3:0]
  // entry: mask,trig,pol,logical,dlv[2:0],dest[7:0],vec[7:0]
  localparam logic [39:0] TBL [0:NROWS-1] = '{
    {3'd2, 1'b0,1'b0,1'b1,1'b0,3'b000,8'h02,8'h31, 2'd1, 8'h31, 4'b0100},
    {3'd3, 1'b0,1'b1,1'b0,1'b0,3'b000,8'hFF,8'h40, 2'd1, 8'h40, 4'b1111},
    {3'd4, 1'b0,1'b0,1'b0,1'b0,3'b010,8'h09,8'h52, 2'd1, 8'h52, 4'b0000},
    {3'd5, 1'b0,1'b1,1'b1,1'b1,3'b000,8'h02,8'h63, 2'd1, 8'h63, 4'b0110},
    {3'd6, 1'b0,1'b0,1'b0,1'b1,3'b100,8'h81,8'h64, 2'd1, 8'h64, 4'b1001},
    {3'd7, 1'b0,1'b0,1'b0,1'b1,3'b000,8'h10,8'h65, 2'd1, 8'h65, 4'b0000},
    {3'd0, 1'b0,1'b0,1'b1,1'b0,3'b111,8'h00,8'h77, 2'd1, 8'hA5, 4'b0001},
    {3'd1, 1'b1,1'b0,1'b0,1'b0,3'b000,8'h01,8'h11, 2'd0, 8'h00, 4'b0000},
    {3'd2, 1'b0,1'b0,1'b0,1'b0,3'b001,8'h01,8'h12, 2'd2, 8'h00, 4'b0000},
    {3'd3, 1'b0,1'b0,1'b0,1'b1,3'b001,8'h03,8'h13, 2'd2, 8'h00, 4'b0000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [EW-1:0] e);
    for (int p = 0; p < NPINS; p++) route_tbl[p*EW +: EW] = e;
  endtask

  task automatic expect_msg(input string req, input logic [7:0] v,
                            input logic [NCPU-1:0] t);
    chk(msg_valid === 1'b1 && msg_vector === v && msg_targets === t && err_pulse === 1'b0,
        req, {msg_valid, err_pulse, msg_vector, msg_targets},
        {1'b1, 1'b0, v, t});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_pins = '0; route_tbl = '0; msg_ready = 1'b1;
    logical_ids = {8'h80, 8'h06, 8'h02, 8'h01};
    legacy_vector = 8'hA5;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(msg_valid === 1'b0 && err_pulse === 1'b0, "R11",
        {msg_valid, err_pulse}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      logic [39:0] r;
      logic [EW-1:0] e;
      int pn;
      r = TBL[i]; e = r[36:14]; pn = int'(r[39:37]);
      set_all(e);
      irq_pins[pn] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      case (r[13:12])
        2'd1: begin
          expect_msg("R1/R4/R5/R6/R7 table", r[11:4], r[3:0]);
          // R3 carried fields
          chk(msg_dlv === e[18:16] && msg_logical === e[19] && msg_level === e[20] &&
              msg_trigger === e[21] && msg_dest === e[15:8], "R3",
              {msg_dlv, msg_logical, msg_level, msg_trigger, msg_dest},
              {e[18:16], e[19], e[20], e[21], e[15:8]});
        end
        2'd2: chk(err_pulse === 1'b1 && msg_valid === 1'b0, "R8",
                  {err_pulse, msg_valid}, 2'b10);
        default: chk(err_pulse === 1'b0 && msg_valid === 1'b0, "R2",
                     {err_pulse, msg_valid}, 2'b00);
      endcase
      @(negedge clk);
      chk(msg_valid === 1'b0 && err_pulse === 1'b0, "R1 steady high",
          {msg_valid, err_pulse}, 2'b00);
      irq_pins[pn] = 1'b0;
      repeat (2) @(negedge clk);
      chk(msg_valid === 1'b0 && err_pulse === 1'b0, "R1 falling",
          {msg_valid, err_pulse}, 2'b00);
    end

    // R9: three pins in one cycle, distinct vectors per pin
    for (int p = 0; p < NPINS; p++)
      route_tbl[p*EW +: EW] = {1'b0,1'b0,1'b0,1'b0,3'b000,8'hFF,8'(8'h10 + p)};
    irq_pins = 8'b0010_1010;
    @(negedge clk);
    @(negedge clk); expect_msg("R9 first", 8'h11, 4'b1111);
    @(negedge clk); expect_msg("R9 second", 8'h13, 4'b1111);
    @(negedge clk); expect_msg("R9 third", 8'h15, 4'b1111);
    @(negedge clk);
    chk(msg_valid === 1'b0, "R9 drained", msg_valid, 1'b0);
    irq_pins = '0;
    repeat (2) @(negedge clk);

    // R10: back-pressure with a second pin pending
    msg_ready = 1'b0;
    irq_pins = 8'b0001_0100;
    @(negedge clk);
    @(negedge clk); expect_msg("R10 loaded", 8'h12, 4'b1111);
    repeat (3) @(negedge clk);
    expect_msg("R10 held", 8'h12, 4'b1111);
    msg_ready = 1'b1;
    @(negedge clk); expect_msg("R10 next after release", 8'h14, 4'b1111);
    @(negedge clk);
    chk(msg_valid === 1'b0, "R10 drained", msg_valid, 1'b0);
    irq_pins = '0;
    repeat (2) @(negedge clk);

    // R8 with R9: lowest-priority pin 0 and normal pin 1 together
    route_tbl[0*EW +: EW] = {1'b0,1'b0,1'b0,1'b0,3'b001,8'h00,8'h20};
    irq_pins = 8'b0000_0011;
    @(negedge clk);
    @(negedge clk);
    chk(err_pulse === 1'b1 && msg_valid === 1'b0, "R8 err first",
        {err_pulse, msg_valid}, 2'b10);
    @(negedge clk); expect_msg("R8 msg after err", 8'h11, 4'b1111);
    irq_pins = '0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule